// File: doc/BRIEF.md
# Half-Wave Volt-Second Error Integrator

This block tracks how far the flux in a full-bridge converter's power transformer drifts from balance. It works one switching period at a time. Two level inputs mark when the primary voltage is in its positive and its negative half-wave. A 16-bit unsigned amplitude sample arrives on every clock. For each half-wave the block counts how many clock cycles the pulse lasts. It also sums the amplitude samples taken during those cycles.

Once both half-waves of a period have ended, the block subtracts the negative sum from the positive sum. The result is the signed volt-second error for that period. The block adds this error to a saturating signed running integral. A bias controller reads the integral and compares it with its own saturation limits. The controller can zero the integral, or overwrite it after it has corrected the duty cycles.

Both detect inputs are asynchronous to the clock, so each passes through a two-flop synchroniser. If the two half-waves are ever seen active at the same time, the period is discarded.

Top module: `vsbal_integrator`

## Requirements
- R1: Each detect input passes through two synchronising flops. A pulse that is high for W consecutive clock edges gives a latched width of exactly W.
- R2: When a half-wave falls, its width is latched to its own output: `pos_cnt_o` for the positive input, `neg_cnt_o` for the negative input. The other output keeps its value.
- R3: Each half-wave's amplitude sum starts from the sample taken in its first cycle. It then adds one 16-bit sample for each further cycle in which the synchronised detect is high. Samples outside the pulse are never added.
- R4: The per-period error on `err_o` equals the positive sum minus the negative sum. It is produced only after both half-waves have ended. `period_done_o` pulses for one cycle on the fourth rising edge after the later input falls.
- R5: In the same cycle as `period_done_o`, `integ_o` becomes the previous integral plus the period error. At all other times it holds, unless cleared or loaded.
- R6: The sum saturates at the 40-bit signed limits, 2^39-1 and -2^39, instead of wrapping.
- R7: `int_clr_i` sets the integral to zero at the next edge. It has priority over a load and over a period update.
- R8: `int_load_i` writes `int_load_val_i` into the integral at the next edge. It has priority over a period update.
- R9: If both synchronised detects are high in the same cycle, that period ends with a one-cycle `fault_o` pulse and no `period_done_o` pulse. `err_o` and the integral are left unchanged.
- R10: After a synchronous reset, all counts, the error, the integral and both strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_det_i | input | 1 | Positive half-wave detect, asynchronous |
| neg_det_i | input | 1 | Negative half-wave detect, asynchronous |
| amp_i | input | 16 | Unsigned amplitude sample |
| int_clr_i | input | 1 | Zero the integral |
| int_load_i | input | 1 | Load the integral from `int_load_val_i` |
| int_load_val_i | input | 40 | Signed value to load |
| pos_cnt_o | output | 12 | Last positive half-wave width, in clock cycles |
| neg_cnt_o | output | 12 | Last negative half-wave width, in clock cycles |
| err_o | output | 29 | Signed per-period volt-second error |
| integ_o | output | 40 | Signed running integral |
| period_done_o | output | 1 | One-cycle strobe: a valid period was added |
| fault_o | output | 1 | One-cycle strobe: an overlapping period was discarded |

## Verification
A raw detect edge reaches the edge logic after two synchroniser flops. The half-wave latch adds a third register and the period combiner a fourth. The bench therefore samples on the falling clock edge: it confirms that `period_done_o` is still low three edges after the last fall and high on the fourth, and reads the counts, error and integral in that same cycle. Clear and load act after one edge, so they are checked on the next falling edge. Amplitudes are held steady from before each pulse until two edges after it, so that each expected sum is exactly width times amplitude.

// File: rtl/vsbal_pkg.sv
package vsbal_pkg;

    localparam int AMP_W       = 16;
    localparam int CNT_W       = 12;
    localparam int ACC_W       = AMP_W + CNT_W;
    localparam int ERR_W       = ACC_W + 1;
    localparam int INT_W       = 40;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_HALVES  = 2;

    typedef logic [AMP_W-1:0]        amp_t;
    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic [ACC_W-1:0]        acc_t;
    typedef logic signed [ERR_W-1:0] err_t;
    typedef logic signed [INT_W-1:0] integ_t;

    typedef struct packed {
        logic done;
        cnt_t cnt;
        acc_t sum;
    } half_res_t;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_GOOD  = 2'd1,
        OUT_FAULT = 2'd2
    } outcome_e;

    function automatic err_t sum_diff(acc_t p, acc_t n);
        return $signed({1'b0, p}) - $signed({1'b0, n});
    endfunction

    function automatic integ_t sat_add(integ_t a, err_t b);
        logic signed [INT_W:0] s;
        s = $signed({a[INT_W-1], a}) + $signed({{(INT_W+1-ERR_W){b[ERR_W-1]}}, b});
        if (s[INT_W] != s[INT_W-1])
            return s[INT_W] ? integ_t'({1'b1, {(INT_W-1){1'b0}}})
                            : integ_t'({1'b0, {(INT_W-1){1'b1}}});
        return integ_t'(s[INT_W-1:0]);
    endfunction

endpackage

// File: rtl/vsbal_sync.sv
module vsbal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic lvl_o,
    output logic lvl_prev_o
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-1:0], d_i};
    end

    assign lvl_o      = sr_q[STAGES-1];
    assign lvl_prev_o = sr_q[STAGES];
endmodule

// File: rtl/vsbal_half.sv
module vsbal_half
    import vsbal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  logic      lvl_prev_i,
    input  amp_t      amp_i,
    output half_res_t res_o
);
    cnt_t      cnt_q;
    acc_t      acc_q;
    half_res_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            res_q.done <= 1'b0;
            if (lvl_i && !lvl_prev_i) begin
                cnt_q <= cnt_t'(1);
                acc_q <= {{(ACC_W-AMP_W){1'b0}}, amp_i};
            end else if (lvl_i) begin
                if (cnt_q != '1) begin
                    cnt_q <= cnt_q + cnt_t'(1);
                    acc_q <= acc_q + {{(ACC_W-AMP_W){1'b0}}, amp_i};
                end
            end else if (lvl_prev_i) begin
                res_q.cnt  <= cnt_q;
                res_q.sum  <= acc_q;
                res_q.done <= 1'b1;
            end
        end
    end

    assign res_o = res_q;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        res_q.done |=> !res_q.done);

    assert_width_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        res_q.done |-> (res_q.cnt != '0));

    assert_start_fresh_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl_i && !lvl_prev_i) |=> (acc_q <= acc_t'({AMP_W{1'b1}})));
endmodule

// File: rtl/vsbal_integrator.sv
module vsbal_integrator
    import vsbal_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pos_det_i,
    input  logic                    neg_det_i,
    input  logic [AMP_W-1:0]        amp_i,
    input  logic                    int_clr_i,
    input  logic                    int_load_i,
    input  logic signed [INT_W-1:0] int_load_val_i,
    output logic [CNT_W-1:0]        pos_cnt_o,
    output logic [CNT_W-1:0]        neg_cnt_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic signed [INT_W-1:0] integ_o,
    output logic                    period_done_o,
    output logic                    fault_o
);
    logic [NUM_HALVES-1:0] det, lvl, lvl_prev, done_now;
    half_res_t             res [NUM_HALVES];

    assign det = {neg_det_i, pos_det_i};

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        vsbal_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst        (rst),
            .d_i        (det[g]),
            .lvl_o      (lvl[g]),
            .lvl_prev_o (lvl_prev[g])
        );
        vsbal_half u_half (
            .clk        (clk),
            .rst        (rst),
            .lvl_i      (lvl[g]),
            .lvl_prev_i (lvl_prev[g]),
            .amp_i      (amp_i),
            .res_o      (res[g])
        );
        assign done_now[g] = res[g].done;
    end

    logic [NUM_HALVES-1:0] seen_q, have;
    logic                  ovl_q, bad;
    err_t                  diff_now, err_q;
    integ_t                integ_q;
    logic                  done_q, fault_q;
    outcome_e              outcome;

    assign have     = seen_q | done_now;
    assign bad      = ovl_q | (&lvl);
    assign diff_now = sum_diff(res[0].sum, res[1].sum);

    always_comb begin
        outcome = OUT_NONE;
        if (&have) outcome = bad ? OUT_FAULT : OUT_GOOD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            ovl_q   <= 1'b0;
            err_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= (outcome == OUT_GOOD);
            fault_q <= (outcome == OUT_FAULT);
            if (outcome == OUT_NONE) begin
                seen_q <= have;
                ovl_q  <= bad;
            end else begin
                seen_q <= '0;
                ovl_q  <= 1'b0;
            end
            if (outcome == OUT_GOOD) err_q <= diff_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     integ_q <= '0;
        else if (int_clr_i)          integ_q <= '0;
        else if (int_load_i)         integ_q <= int_load_val_i;
        else if (outcome == OUT_GOOD) integ_q <= sat_add(integ_q, diff_now);
    end

    assign pos_cnt_o     = res[0].cnt;
    assign neg_cnt_o     = res[1].cnt;
    assign err_o         = err_q;
    assign integ_o       = integ_q;
    assign period_done_o = done_q;
    assign fault_o       = fault_q;

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        int_clr_i |=> (integ_q == '0));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        (int_load_i && !int_clr_i) |=> (integ_q == $past(int_load_val_i)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!int_clr_i && !int_load_i) |=> ($stable(integ_q) || done_q));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done_q && fault_q));

    assert_fault_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !$past(int_clr_i) && !$past(int_load_i)) |-> $stable(integ_q));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (done_q && !err_q[ERR_W-1] && !$past(int_clr_i) && !$past(int_load_i))
            |-> ($signed(integ_q) >= $signed($past(integ_q))));
endmodule

// File: tb/vsbal_integrator_bench.sv
module vsbal_integrator_bench;
    import vsbal_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos = 1'b0, neg = 1'b0;
    amp_t amp = '0;
    logic clr = 1'b0, load = 1'b0;
    integ_t lval = '0;
    cnt_t pcnt, ncnt;
    err_t err;
    integ_t integ;
    logic pdone, fault;

    int n_chk = 0, n_bad = 0;
    longint exp_int = 0;
    bit finished = 0;
    localparam longint IMAX = (64'sd1 <<< (INT_W-1)) - 1;
    localparam longint IMIN = -(64'sd1 <<< (INT_W-1));

    always #4 clk = ~clk;

    vsbal_integrator u_vsbal_integrator (
        .clk(clk), .rst(rst), .pos_det_i(pos), .neg_det_i(neg), .amp_i(amp),
        .int_clr_i(clr), .int_load_i(load), .int_load_val_i(lval),
        .pos_cnt_o(pcnt), .neg_cnt_o(ncnt), .err_o(err), .integ_o(integ),
        .period_done_o(pdone), .fault_o(fault)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic period(int wp, int ap, int wn, int an);
        longint e;
        @(negedge clk); amp = amp_t'(ap); pos = 1'b1;
        repeat (wp) @(negedge clk);
        pos = 1'b0;
        repeat (4) @(negedge clk);
        amp = amp_t'(an); neg = 1'b1;
        repeat (wn) @(negedge clk);
        neg = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 strobe not yet", longint'(pdone), 0);
        @(negedge clk);
        chk("R4 strobe due", longint'(pdone), 1);
        chk("R1 R2 positive width", longint'(pcnt), wp);
        chk("R1 R2 negative width", longint'(ncnt), wn);
        e = longint'(wp) * ap - longint'(wn) * an;
        chk("R3 R4 period error", longint'(err), e);
        exp_int = exp_int + e;
        if (exp_int > IMAX) exp_int = IMAX;
        if (exp_int < IMIN) exp_int = IMIN;
        chk("R5 R6 integral", longint'(integ), exp_int);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset pos width", longint'(pcnt), 0);
        chk("R10 reset neg width", longint'(ncnt), 0);
        chk("R10 reset error", longint'(err), 0);
        chk("R10 reset integral", longint'(integ), 0);
        chk("R10 reset strobes", longint'({pdone, fault}), 0);

        for (int wi = 0; wi < 4; wi++) begin
            for (int ni = 0; ni < 3; ni++) begin
                int wp, wn;
                wp = (wi == 0) ? 1 : (wi == 1) ? 4 : (wi == 2) ? 9 : 25;
                wn = (ni == 0) ? 1 : (ni == 1) ? 6 : 25;
                period(wp, 100 + wi * 1000 + 37 * ni, wn, 3000 - 200 * wi + 50 * ni);
            end
        end

        // R9: overlapping half-waves discard the period
        begin
            longint keep_err;
            keep_err = longint'(err);
            @(negedge clk); amp = 16'd500; pos = 1'b1;
            repeat (3) @(negedge clk); neg = 1'b1;
            repeat (3) @(negedge clk); pos = 1'b0;
            repeat (3) @(negedge clk); neg = 1'b0;
            repeat (3) @(negedge clk);
            chk("R9 no fault yet", longint'(fault), 0);
            @(negedge clk);
            chk("R9 fault strobe", longint'(fault), 1);
            chk("R9 no done strobe", longint'(pdone), 0);
            chk("R9 integral kept", longint'(integ), exp_int);
            chk("R9 error kept", longint'(err), keep_err);
        end
        period(5, 200, 5, 100);

        // R7: clear, also over a simultaneous load
        @(negedge clk); clr = 1'b1; load = 1'b1; lval = 40'sd777;
        @(negedge clk); clr = 1'b0; load = 1'b0;
        exp_int = 0;
        chk("R7 clear wins", longint'(integ), 0);

        // R8: load, then accumulate from the loaded value
        @(negedge clk); load = 1'b1; lval = -40'sd12345;
        @(negedge clk); load = 1'b0;
        exp_int = -12345;
        chk("R8 load", longint'(integ), exp_int);
        period(3, 1000, 2, 10);

        // R6: saturation at both limits
        @(negedge clk); load = 1'b1; lval = integ_t'(IMAX - 5);
        @(negedge clk); load = 1'b0; exp_int = IMAX - 5;
        period(10, 100, 1, 0);
        chk("R6 upper limit", longint'(integ), IMAX);
        @(negedge clk); load = 1'b1; lval = integ_t'(IMIN + 5);
        @(negedge clk); load = 1'b0; exp_int = IMIN + 5;
        period(1, 0, 10, 100);
        chk("R6 lower limit", longint'(integ), IMIN);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule